// File: doc/BRIEF.md
# Bi-phase lighting-bus frame transmitter

This block sends one 16-bit forward command onto a two-wire lighting control bus. The upper byte (address) goes first, then the lower byte (command data). A host offers the word with a valid/ready handshake. The block then serializes the word as a start bit, the sixteen bits in bi-phase code, and a stop period during which the line stays idle.

Every bit occupies two half-bit symbol slots. The slot length comes from a clock-enable divider. It is set so that the bus sees 2400 symbols per second, which is 1200 bits per second. The transmit pin drives an open-collector sink, so the pin is the inverse of the bus level: a high pin pulls the bus low, and a low pin leaves the bus at its idle high level. While a frame is in flight the block reports busy and takes no new word. A one-cycle done pulse marks the end of the stop period.

Top module: `lbus_frame_tx`

## Requirements
- R1: After reset `tx_pin` is 0, `frame_ready` is 1, `busy` is 0 and `done` is 0. Whenever the block is idle and no word is offered, `tx_pin` is 0.
- R2: A word is accepted in a cycle where `frame_valid` and `frame_ready` are both 1. From the next cycle `busy` is 1 and `frame_ready` is 0. Both keep those values until the cycle in which `done` is raised.
- R3: The frame opens with a start bit of logic 1. `tx_pin` is 1 for slot 0, starting combinationally in the acceptance cycle, and 0 for slot 1.
- R4: Each data bit takes two slots. A logic 1 gives bus levels low then high, which is `tx_pin` 1 then 0. A logic 0 gives bus levels high then low, which is `tx_pin` 0 then 1.
- R5: Bits are sent most significant first. `frame_data[15:8]` (address) occupies slots 2 to 17 and `frame_data[7:0]` (data) occupies slots 18 to 33.
- R6: Every slot lasts exactly CLKS_PER_SYMBOL clock cycles (at least 2). Slot k covers cycles k*CLKS_PER_SYMBOL to k*CLKS_PER_SYMBOL+CLKS_PER_SYMBOL-1, counted from the acceptance cycle as 0. `tx_pin` changes only at a slot boundary.
- R7: Slots 34 to 37 form the stop period, with `tx_pin` 0 (bus idle high).
- R8: `done` is 1 for exactly one cycle, at cycle 38*CLKS_PER_SYMBOL after acceptance. In that cycle `busy` is 0 and `frame_ready` is 1.
- R9: A `frame_valid` raised while `busy` is 1 is ignored. The frame in flight keeps its waveform and no second frame follows it.
- R10: A word offered in the `done` cycle is accepted there. Its first slot starts in that same cycle, so frames follow with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Host offers a word |
| frame_data | input | 16 | Word: address in [15:8], data in [7:0] |
| frame_ready | output | 1 | Block idle and able to accept |
| tx_pin | output | 1 | Sink drive; 1 pulls the bus low |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at end of stop period |

## Verification
The end-of-frame `done` pulse and the acceptance of the next word can fall in one cycle. The acceptance also starts the first slot of the next frame combinationally in that cycle. The bench provokes this by chaining frames: it raises `frame_valid` with a new word in the exact cycle it expects `done`. It then judges that `done` and `frame_ready` are both high, that `tx_pin` is already 1, and that the second frame matches its own waveform cycle by cycle. A second overlap is a `frame_valid` offered mid-frame while busy. It is judged by comparing every cycle of the running frame against the expected waveform.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    localparam int unsigned FRAME_BITS     = 16;
    localparam int unsigned START_SLOTS    = 2;
    localparam int unsigned DATA_SLOTS     = 2 * FRAME_BITS;
    localparam int unsigned STOP_SLOTS     = 4;
    localparam int unsigned SLOTS_PER_FRAME = START_SLOTS + DATA_SLOTS + STOP_SLOTS;
    localparam int unsigned SLOT_IDX_W     = $clog2(SLOTS_PER_FRAME);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        tx_state_e                 st;
        logic [SLOT_IDX_W-1:0]     slot;
        logic [FRAME_BITS-1:0]     word;
    } tx_ctx_t;

    // Pin level (inverse of bus level) for a given slot of a frame.
    function automatic logic slot_pin(input logic [FRAME_BITS-1:0] w,
                                      input logic [SLOT_IDX_W-1:0] slot);
        int unsigned s;
        int unsigned rel;
        int unsigned bitpos;
        logic        b;
        s = int'(slot);
        if (s < START_SLOTS) begin
            return (s == 0);
        end else if (s < START_SLOTS + DATA_SLOTS) begin
            rel    = s - START_SLOTS;
            bitpos = FRAME_BITS - 1 - (rel / 2);
            b      = w[bitpos];
            return ((rel % 2) == 0) ? b : ~b;
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/lbus_symbol_timer.sv
module lbus_symbol_timer #(
    parameter int unsigned CLKS_PER_SYMBOL = 20833
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(CLKS_PER_SYMBOL);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_SYMBOL - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_LAST);

    // The acceptance cycle already counts as the first cycle of slot 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(1);
        end else if (run) begin
            cnt <= tick ? '0 : cnt + CNT_W'(1);
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/lbus_slot_coder.sv
module lbus_slot_coder
    import lbus_pkg::*;
(
    input  logic                  launch,
    input  logic [FRAME_BITS-1:0] launch_word,
    input  logic                  sending,
    input  logic [SLOT_IDX_W-1:0] slot,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  pin
);
    always_comb begin
        if (launch) begin
            pin = slot_pin(launch_word, '0);
        end else if (sending) begin
            pin = slot_pin(word, slot);
        end else begin
            pin = 1'b0;
        end
    end

endmodule

// File: rtl/lbus_frame_tx.sv
module lbus_frame_tx
    import lbus_pkg::*;
#(
    parameter int unsigned CLKS_PER_SYMBOL = 20833
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_valid,
    input  logic [15:0] frame_data,
    output logic        frame_ready,
    output logic        tx_pin,
    output logic        busy,
    output logic        done
);
    localparam logic [SLOT_IDX_W-1:0] SLOT_LAST = SLOT_IDX_W'(SLOTS_PER_FRAME - 1);

    tx_ctx_t ctx;
    logic    accept;
    logic    tick;
    logic    sending;

    assign sending     = (ctx.st == ST_SEND);
    assign frame_ready = !sending;
    assign busy        = sending;
    assign accept      = frame_valid && frame_ready;

    lbus_symbol_timer #(
        .CLKS_PER_SYMBOL(CLKS_PER_SYMBOL)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .run  (sending),
        .tick (tick)
    );

    lbus_slot_coder u_coder (
        .launch      (accept),
        .launch_word (frame_data),
        .sending     (sending),
        .slot        (ctx.slot),
        .word        (ctx.word),
        .pin         (tx_pin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.st   <= ST_IDLE;
            ctx.slot <= '0;
            ctx.word <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ctx.st)
                ST_IDLE: begin
                    if (accept) begin
                        ctx.st   <= ST_SEND;
                        ctx.slot <= '0;
                        ctx.word <= frame_data;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (ctx.slot == SLOT_LAST) begin
                            ctx.st <= ST_IDLE;
                            done   <= 1'b1;
                        end else begin
                            ctx.slot <= ctx.slot + SLOT_IDX_W'(1);
                        end
                    end
                end
                default: ctx.st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lbus_frame_tx_chk.sv
module lbus_frame_tx_chk #(
    parameter int unsigned CLKS_PER_SYMBOL = 20833
) (
    input logic        clk,
    input logic        rst,
    input logic        frame_valid,
    input logic [15:0] frame_data,
    input logic        frame_ready,
    input logic        tx_pin,
    input logic        busy,
    input logic        done
);
    localparam int unsigned CW = $clog2(CLKS_PER_SYMBOL) + 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SYMBOL - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (frame_valid && frame_ready) begin
            phase <= CW'(1);
        end else if (busy) begin
            phase <= (phase == LAST) ? '0 : phase + CW'(1);
        end else begin
            phase <= '0;
        end
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_ready && !frame_valid) |-> !tx_pin);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_ready) |=> (busy && !frame_ready));

    p_start_pin_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_ready) |-> tx_pin);

    p_slot_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && (phase != '0)) |-> $stable(tx_pin));

    p_done_ready_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_ready && !busy));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_to_done_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind lbus_frame_tx lbus_frame_tx_chk #(
    .CLKS_PER_SYMBOL(CLKS_PER_SYMBOL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_ready (frame_ready),
    .tx_pin      (tx_pin),
    .busy        (busy),
    .done        (done)
);

// File: tb/sim_lbus_frame_tx.sv
module sim_lbus_frame_tx;
    localparam int N = 4;
    localparam int SLOTS = 38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [15:0] frame_data = '0;
    logic        frame_ready, tx_pin, busy, done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lbus_frame_tx #(.CLKS_PER_SYMBOL(N)) u0 (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_ready(frame_ready), .tx_pin(tx_pin), .busy(busy), .done(done)
    );

    // Expected pin level: bus levels built from R3/R4/R5/R7, pin is inverse.
    function automatic bit exp_pin(input logic [15:0] d, input int k);
        bit [0:SLOTS-1] bus;
        bus[0] = 1'b0;
        bus[1] = 1'b1;
        for (int i = 0; i < 16; i++) begin
            bus[2 + 2*i] = d[15-i] ? 1'b0 : 1'b1;
            bus[3 + 2*i] = d[15-i] ? 1'b1 : 1'b0;
        end
        for (int i = 34; i < SLOTS; i++) bus[i] = 1'b1;
        return ~bus[k];
    endfunction

    function automatic string slot_req(input int k);
        if (k < 2)  return "R3";
        if (k < 34) return "R4/R5";
        return "R7";
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Caller is in the low phase of a cycle; that cycle is cycle 0 of the frame.
    task automatic run_frame(input logic [15:0] d, input bit noise, input bit chain);
        string tag;
        frame_valid = 1'b1;
        frame_data  = d;
        for (int j = 0; j <= SLOTS*N; j++) begin
            if (j > 0) begin
                @(negedge clk);
                if (j == 1) frame_valid = 1'b0;
                if (noise && j >= 5 && j <= 8) begin
                    frame_valid = 1'b1;
                    frame_data  = ~d;
                end
                if (noise && j == 9) frame_valid = 1'b0;
            end
            #1;
            if (j < SLOTS*N) begin
                // R6: every cycle sampled; slot index is j / N.
                if (noise)            tag = "R9";
                else if (j % N != 0)  tag = "R6";
                else                  tag = slot_req(j / N);
                check(tag, "tx_pin", tx_pin, exp_pin(d, j / N));
                if (j == 0) begin
                    check("R2", "ready before accept", frame_ready, 1'b1);
                end else begin
                    check(noise ? "R9" : "R2", "busy", busy, 1'b1);
                    check("R2", "ready low", frame_ready, 1'b0);
                end
                if (j == 1) check("R8", "no early done", done, 1'b0);
            end else begin
                check("R8", "done at end", done, 1'b1);
                check("R8", "ready with done", frame_ready, 1'b1);
                check("R8", "busy low with done", busy, 1'b0);
            end
        end
        if (!chain) begin
            @(negedge clk);
            #1;
            check("R8", "done one cycle", done, 1'b0);
            check("R9", "no second frame", busy, 1'b0);
            check("R1", "idle pin", tx_pin, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check("R1", "reset tx_pin", tx_pin, 1'b0);
        check("R1", "reset ready", frame_ready, 1'b1);
        check("R1", "reset busy", busy, 1'b0);
        check("R1", "reset done", done, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R1", "idle after reset", tx_pin, 1'b0);
        @(negedge clk);

        run_frame(16'h0000, 1'b0, 1'b0);
        run_frame(16'hFFFF, 1'b0, 1'b0);
        run_frame(16'h8001, 1'b0, 1'b0);   // R5 MSB-first ordering
        run_frame(16'hA55A, 1'b1, 1'b0);   // R9 offer while busy
        // R10: chain frames with the next word offered in the done cycle
        run_frame(16'h1234, 1'b0, 1'b1);
        run_frame(16'hFE01, 1'b0, 1'b1);
        run_frame(16'h00FF, 1'b0, 1'b0);

        for (int n = 0; n < 10; n++) begin
            w = 16'($urandom);
            run_frame(w, n % 3 == 0, n % 4 == 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule